// File: doc/BRIEF.md
# Serial DAC Input Register and Latch

This block is the digital front end of a serial-input, voltage-output converter. A host frames a word with an active-low chip select and clocks it in most significant bit first on a serial clock and a data line. Each word is 16 bits long: fourteen code bits followed by two trailing sub-bits. The word goes into a shift register. When the frame is accepted, its fourteen code bits move into the latch that feeds the converter core.

An active-low load strobe chooses when the latch takes the word. If the strobe is held low, the latch updates as soon as chip select rises. If the strobe is held high while a frame loads, the captured word waits, and a later falling edge of the strobe commits it. A frame that saw any clock count other than 16 is discarded. A sticky flag reports the rejection until a correct frame arrives. Every pin is brought into the system clock domain through a two-flop synchroniser before any edge is detected. Reset clears the latch to code zero.

Top module: `sdac_front`

## Requirements
- R1: After reset the latched code is 0 and the rejection flag is 0.
- R2: A frame of exactly 16 serial-clock rising edges, with the load strobe low, puts its first fourteen bits into the code when chip select rises. The first bit becomes code bit 13 and the fourteenth bit becomes code bit 0.
- R3: The 15th and 16th bits of a frame (the sub-bits) never reach the code, whatever their values.
- R4: When chip select rises after a frame with any number of clock edges other than 16 (zero, 15 or 17, for example), the code stays unchanged and the rejection flag goes to 1.
- R5: The rejection flag holds until the next frame with exactly 16 clock edges, which clears it to 0.
- R6: If the load strobe is high when a valid frame ends, the code stays unchanged. The code then takes that frame's word on the next falling edge of the load strobe.
- R7: A falling edge of the load strobe has no effect on the code unless a valid frame has been held back since the last latch update. A falling chip select or a rejected frame cancels any held word.
- R8: Serial-clock edges that occur while chip select is high neither shift data nor count toward a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| din | input | 1 | Serial data, MSB first |
| loadN | input | 1 | Active-low latch load strobe |
| code | output | 14 | Latched converter code |
| frameErr | output | 1 | Last completed frame had a wrong clock count |

## Verification
The assertions assume every host pin is slow compared with the system clock. Each level of chip select, serial clock and load strobe must last several system cycles, so no edge is lost in the synchronisers, and data must be stable around each serial-clock rise. The bench holds every serial-clock phase for three system cycles and changes data only at the start of a low phase. It gives chip select four cycles of margin on both sides of the clock burst and changes the load strobe only while no frame is active. Under these rules a single synchronised edge stands for each host edge, which the counter and code-stability properties rely on.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Positions of the host pins inside the synchroniser vector
  localparam int IDX_CS   = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_DIN  = 2;
  localparam int IDX_LOAD = 3;
  localparam int PIN_CNT  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadLatch;
  } dpStrobe_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], asyncIn};
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csLvl,
  input  logic      sclkLvl,
  input  logic      loadLvl,
  output dpStrobe_t st,
  output logic      frameErr
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic csPrv, sclkPrv, loadPrv;
  logic csRise, csFall, sclkRise, loadFall, frameOk;
  logic [CNT_W-1:0] cnt;
  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrv   <= 1'b1;
      sclkPrv <= 1'b0;
      loadPrv <= 1'b1;
    end else begin
      csPrv   <= csLvl;
      sclkPrv <= sclkLvl;
      loadPrv <= loadLvl;
    end
  end

  assign csRise   = csLvl & ~csPrv;
  assign csFall   = ~csLvl & csPrv;
  assign sclkRise = sclkLvl & ~sclkPrv;
  assign loadFall = ~loadLvl & loadPrv;
  assign frameOk  = csRise && (cnt == CNT_FULL);

  always_comb begin
    st.shiftEn   = sclkRise && !csLvl;
    st.loadLatch = (frameOk && !loadLvl) || (loadFall && pending);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      pending  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (csFall)                           cnt <= st.shiftEn ? CNT_W'(1) : '0;
      else if (st.shiftEn && cnt != CNT_MAX) cnt <= cnt + 1'b1;

      if (csFall || st.loadLatch || (csRise && !frameOk)) pending <= 1'b0;
      else if (frameOk && loadLvl)                       pending <= 1'b1;

      if (csRise) frameErr <= !frameOk;
    end
  end

  p_bad_frame_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && cnt != CNT_FULL) |=> frameErr);
  p_good_frame_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && cnt == CNT_FULL) |=> !frameErr);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);
  p_idle_no_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csLvl && $past(csLvl)) |=> $stable(cnt));
  p_pending_consumed_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.loadLatch |=> !pending);
endmodule

// File: rtl/sdac_dpath.sv
module sdac_dpath
  import sdac_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SUB_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinLvl,
  input  dpStrobe_t         st,
  output logic [DATA_W-1:0] code
);
  localparam int FRAME_W = DATA_W + SUB_W;

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      code     <= '0;
    end else begin
      if (st.shiftEn)   shiftReg <= {shiftReg[FRAME_W-2:0], dinLvl};
      if (st.loadLatch) code     <= shiftReg[FRAME_W-1:SUB_W];
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> code == '0);
  p_code_only_on_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (code != $past(code)) |-> $past(st.loadLatch));
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SUB_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              loadN,
  output logic [DATA_W-1:0] code,
  output logic              frameErr
);
  localparam int FRAME_W = DATA_W + SUB_W;
  localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'((1 << IDX_CS) | (1 << IDX_LOAD));

  logic [PIN_CNT-1:0] pinRaw, pinSync;
  dpStrobe_t          strobe;

  always_comb begin
    pinRaw           = '0;
    pinRaw[IDX_CS]   = csN;
    pinRaw[IDX_SCLK] = sclk;
    pinRaw[IDX_DIN]  = din;
    pinRaw[IDX_LOAD] = loadN;
  end

  sdac_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(pinRaw), .syncOut(pinSync)
  );

  sdac_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .csLvl(pinSync[IDX_CS]), .sclkLvl(pinSync[IDX_SCLK]), .loadLvl(pinSync[IDX_LOAD]),
    .st(strobe), .frameErr(frameErr)
  );

  sdac_dpath #(.DATA_W(DATA_W), .SUB_W(SUB_W)) dpath_i (
    .clk(clk), .rstN(rstN), .dinLvl(pinSync[IDX_DIN]), .st(strobe), .code(code)
  );
endmodule

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, din = 1'b0, loadN = 1'b0;
  logic [13:0] code;
  logic frameErr;
  int checkCnt = 0, failCnt = 0;
  logic [13:0] expCode = '0;
  bit done = 0;

  always #2 clk = ~clk;

  sdac_front dut_i (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
                    .loadN(loadN), .code(code), .frameErr(frameErr));

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleClocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclkPulse(input logic bitVal);
    din = bitVal;
    idleClocks(3);
    sclk = 1'b1;
    idleClocks(3);
    sclk = 1'b0;
  endtask

  task automatic sendFrame(input logic [15:0] w, input int nClk);
    csN = 1'b0;
    idleClocks(4);
    for (int i = 0; i < nClk; i++) sclkPulse(i < 16 ? w[15-i] : 1'b1);
    idleClocks(4);
    csN = 1'b1;
    idleClocks(8);
  endtask

  initial begin
    idleClocks(3);
    rstN = 1'b1;
    idleClocks(2);
    check("R1 code after reset", code, 0);
    check("R1 flag after reset", frameErr, 0);

    // R2/R3: walking ones with sub-bits set
    for (int b = 0; b < 14; b++) begin
      expCode = 14'(1 << b);
      sendFrame({expCode, 2'b11}, 16);
      check("R2 walking one", code, expCode);
    end
    // R2/R3: arithmetic sweep with varying sub-bits
    for (int k = 0; k < 40; k++) begin
      expCode = 14'((k * 1237 + 5) & 14'h3fff);
      sendFrame({expCode, 2'(k & 3)}, 16);
      check("R3 sweep code", code, expCode);
      check("R2 sweep flag", frameErr, 0);
    end

    // R4: wrong clock counts
    sendFrame(16'h5555, 15);
    check("R4 short frame code", code, expCode);
    check("R4 short frame flag", frameErr, 1);
    sendFrame(16'h0f0f, 16);
    expCode = 14'h03c3;
    check("R5 flag cleared", frameErr, 0);
    check("R5 code after recovery", code, expCode);
    sendFrame(16'hffff, 17);
    check("R4 long frame code", code, expCode);
    check("R4 long frame flag", frameErr, 1);
    sendFrame(16'h1234, 0);
    check("R4 empty frame code", code, expCode);
    check("R4 empty frame flag", frameErr, 1);
    sendFrame(16'h8001, 16);
    expCode = 14'h2000;
    check("R5 flag cleared again", frameErr, 0);
    check("R5 code", code, expCode);

    // R6: deferred load
    loadN = 1'b1;
    idleClocks(4);
    sendFrame(16'h9abc, 16);
    check("R6 held code", code, expCode);
    loadN = 1'b0;
    idleClocks(8);
    expCode = 14'h26af;
    check("R6 strobe commit", code, expCode);
    loadN = 1'b1;
    idleClocks(4);

    // R8: stray clocks with chip select high do not touch a held word
    sendFrame(16'h4444, 16);
    for (int i = 0; i < 5; i++) sclkPulse(1'b1);
    idleClocks(4);
    check("R8 stray clocks code", code, expCode);
    loadN = 1'b0;
    idleClocks(8);
    expCode = 14'h1111;
    check("R8 held word intact", code, expCode);
    loadN = 1'b1;
    idleClocks(4);

    // R7: rejected frame cancels held word, strobe then ignored
    sendFrame(16'h7ffc, 16);
    sendFrame(16'h0003, 15);
    check("R7 flag", frameErr, 1);
    loadN = 1'b0;
    idleClocks(8);
    check("R7 strobe ignored", code, expCode);
    loadN = 1'b1;
    idleClocks(4);
    loadN = 1'b0;
    idleClocks(8);
    check("R7 second strobe ignored", code, expCode);

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule